// File: doc/BRIEF.md
# Slot-Reserved Priority Link Arbiter

This block decides, every clock cycle, which of several traffic flows may drive one shared output link. Some flows hold reserved cycles: a small programmable table of time slots is stepped through once per cycle. Each valid slot names the flow that owns that cycle. When the owner is requesting and allowed to send, it gets the link. Otherwise the cycle goes straight to best-effort arbitration, so no bandwidth is left idle.

Best-effort arbitration works by class. Flows are split into a high and a low class by a parameter mask. A high-class request normally beats a low-class one. A round-robin pointer keeps the order fair inside each class. A starvation counter caps how long the low class can keep losing: after a set number of consecutive lost cycles, the low class takes the next best-effort grant. Each flow also passes through its own token bucket. A flow with an empty bucket is treated as not requesting, which caps its injection rate.

The result is a registered one-hot grant vector and a link-valid flag, both one cycle after the request that produced them. Packet framing, routing and data buffering are handled outside the block.

Top module: `lnk_arb`

## Requirements
- R1: While reset is asserted, `gnt` is all zero and `link_valid` is 0. After reset every slot is invalid, the slot pointer is 0, every token bucket is full (`TOK_MAX`), and the starvation count is 0.
- R2: `gnt` is zero or one-hot. A bit set after a clock edge belongs to a flow whose `req` was high before that edge. The decision made on edge k is visible from edge k onward, until edge k+1.
- R3: The slot pointer advances by one entry per cycle and wraps from `SLOTS-1` to 0. When the current slot is valid and its owner flow is eligible, that flow is granted.
- R4: When the current slot is invalid, or its owner is not eligible, the same cycle is granted by best-effort arbitration among all eligible flows.
- R5: In best-effort arbitration, an eligible flow whose bit in `HI_MASK` is 1 wins over eligible low flows, unless the low class is starving (R7).
- R6: Within a class, grants rotate round-robin. The search starts at the flow after the class's last best-effort grant, in ascending index order with wrap. The initial last index is `NUM_FLOWS-1`.
- R7: The starvation count rises by one, saturating at `STARVE_LIMIT`, each cycle in which a low flow is eligible but no low flow is granted. It clears otherwise. When it equals `STARVE_LIMIT` and a low flow is eligible, the best-effort grant goes to the low class. A valid reserved slot still takes precedence.
- R8: A flow is eligible only if `req` is high and its token count is nonzero. Each grant removes one token.
- R9: A refill tick occurs every `REFILL_PERIOD` cycles, on the cycle where the divider reaches `REFILL_PERIOD-1`, counting from 0 after reset. On a tick each bucket gains one token after any grant is subtracted, capped at `TOK_MAX`.
- R10: `link_valid` is 1 exactly when `gnt` is nonzero.
- R11: A write with `tbl_we` high stores `tbl_valid`, a valid flag, and `tbl_flow`, the owner's flow index, into entry `tbl_addr`. The new value is first used on the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_FLOWS | Per-flow request |
| tbl_we | input | 1 | Slot-table write enable |
| tbl_addr | input | $clog2(SLOTS) | Slot index written |
| tbl_valid | input | 1 | Valid flag for the written slot |
| tbl_flow | input | $clog2(NUM_FLOWS) | Owner flow index for the written slot |
| gnt | output | NUM_FLOWS | Registered one-hot grant |
| link_valid | output | 1 | Link carries a granted flow this cycle |

## Verification
Two high-class flows requesting alone show round-robin alternation and token drain against refill. Adding a low flow behind a saturating high pair separates plain priority from the starvation override, because the low grant must appear on exactly the bounded cycle. Programming reserved slots while every flow requests shows that reserved cycles land at fixed frame positions. Requesting only from non-owners then shows that an idle reservation falls through to best-effort in the same cycle. Clearing a slot afterwards shows that table writes take effect on the following cycle.

// File: rtl/lnk_arb_pkg.sv
package lnk_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TDM  = 2'd1,
    SRC_HI   = 2'd2,
    SRC_LO   = 2'd3
  } grant_src_e;

  localparam int CLS_LO = 0;
  localparam int CLS_HI = 1;
  localparam int NUM_CLS = 2;

endpackage

// File: rtl/lnk_slot_table.sv
module lnk_slot_table #(
  parameter int SLOTS  = 8,
  parameter int FLOW_W = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic [FLOW_W-1:0] wr_flow,
  output logic [SLOT_W-1:0] ptr,
  output logic              cur_valid,
  output logic [FLOW_W-1:0] cur_flow
);

  logic [SLOTS-1:0]  vld_q;
  logic [FLOW_W-1:0] own_q [SLOTS];
  logic [SLOT_W-1:0] ptr_q, ptr_d;

  always_comb begin
    if (int'(ptr_q) == SLOTS - 1) ptr_d = '0;
    else                          ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (int'(wr_addr) == s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        own_q[s] <= '0;
      end else if (hit) begin
        vld_q[s] <= wr_valid;
        own_q[s] <= wr_flow;
      end
    end
  end

  assign ptr       = ptr_q;
  assign cur_valid = vld_q[ptr_q];
  assign cur_flow  = own_q[ptr_q];

endmodule

// File: rtl/lnk_token_bucket.sv
module lnk_token_bucket #(
  parameter int TOK_W   = 4,
  parameter int TOK_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refill,
  input  logic consume,
  output logic nonzero
);

  logic [TOK_W-1:0] cnt_q, cnt_d;
  logic [TOK_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} - {{TOK_W{1'b0}}, consume} + {{TOK_W{1'b0}}, refill};
    if (int'(sum) > TOK_MAX) cnt_d = TOK_W'(TOK_MAX);
    else                     cnt_d = sum[TOK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TOK_W'(TOK_MAX);
    else        cnt_q <= cnt_d;
  end

  assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/lnk_class_rr.sv
module lnk_class_rr #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig,
  input  logic         adv,
  output logic [N-1:0] pick
);

  logic [IW-1:0] last_q, last_d;

  always_comb begin
    int idx;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!found && elig[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (adv) begin
      for (int i = 0; i < N; i++) begin
        if (pick[i]) last_d = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/lnk_arb.sv
module lnk_arb
  import lnk_arb_pkg::*;
#(
  parameter int NUM_FLOWS     = 4,
  parameter int SLOTS         = 8,
  parameter int TOK_W         = 4,
  parameter int TOK_MAX       = 4,
  parameter int REFILL_PERIOD = 8,
  parameter int STARVE_LIMIT  = 15,
  parameter logic [NUM_FLOWS-1:0] HI_MASK = 4'b0011,
  localparam int FLOW_W = $clog2(NUM_FLOWS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int DIV_W  = (REFILL_PERIOD > 1) ? $clog2(REFILL_PERIOD) : 1,
  localparam int STV_W  = $clog2(STARVE_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLOWS-1:0] req,
  input  logic                 tbl_we,
  input  logic [SLOT_W-1:0]    tbl_addr,
  input  logic                 tbl_valid,
  input  logic [FLOW_W-1:0]    tbl_flow,
  output logic [NUM_FLOWS-1:0] gnt,
  output logic                 link_valid
);

  logic [SLOT_W-1:0]    slot_ptr;
  logic                 cur_valid;
  logic [FLOW_W-1:0]    cur_flow;
  logic [NUM_FLOWS-1:0] tok_nz, elig, hi_elig, lo_elig, tdm_vec, gnt_d, gnt_q;
  logic                 tdm_hit, link_q, refill_tick, starve_flag, lo_served;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [STV_W-1:0]     stv_q, stv_d;
  logic [NUM_FLOWS-1:0] cls_elig [NUM_CLS];
  logic [NUM_FLOWS-1:0] cls_pick [NUM_CLS];
  logic [NUM_CLS-1:0]   cls_adv;
  grant_src_e           src;

  lnk_slot_table #(.SLOTS(SLOTS), .FLOW_W(FLOW_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_valid(tbl_valid), .wr_flow(tbl_flow),
    .ptr(slot_ptr), .cur_valid(cur_valid), .cur_flow(cur_flow)
  );

  // refill divider
  always_comb begin
    refill_tick = (int'(div_q) == REFILL_PERIOD - 1);
    div_d       = refill_tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    lnk_token_bucket #(.TOK_W(TOK_W), .TOK_MAX(TOK_MAX)) u_bkt (
      .clk(clk), .rst_n(rst_n),
      .refill(refill_tick), .consume(gnt_d[f]), .nonzero(tok_nz[f])
    );
    assign tdm_vec[f] = (cur_flow == FLOW_W'(f));
  end

  assign elig    = req & tok_nz;
  assign hi_elig = elig & HI_MASK;
  assign lo_elig = elig & ~HI_MASK;
  assign tdm_hit = cur_valid && ((elig & tdm_vec) != '0);

  assign cls_elig[CLS_LO] = lo_elig;
  assign cls_elig[CLS_HI] = hi_elig;
  assign cls_adv[CLS_LO]  = (src == SRC_LO);
  assign cls_adv[CLS_HI]  = (src == SRC_HI);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    lnk_class_rr #(.N(NUM_FLOWS)) u_rr (
      .clk(clk), .rst_n(rst_n),
      .elig(cls_elig[c]), .adv(cls_adv[c]), .pick(cls_pick[c])
    );
  end

  assign starve_flag = (int'(stv_q) == STARVE_LIMIT);

  always_comb begin
    if (tdm_hit)                           src = SRC_TDM;
    else if (starve_flag && (|lo_elig))    src = SRC_LO;
    else if (|hi_elig)                     src = SRC_HI;
    else if (|lo_elig)                     src = SRC_LO;
    else                                   src = SRC_NONE;
    case (src)
      SRC_TDM: gnt_d = tdm_vec;
      SRC_HI:  gnt_d = cls_pick[CLS_HI];
      SRC_LO:  gnt_d = cls_pick[CLS_LO];
      default: gnt_d = '0;
    endcase
  end

  // starvation bound for the low class
  always_comb begin
    lo_served = (gnt_d & ~HI_MASK) != '0;
    if ((|lo_elig) && !lo_served)
      stv_d = starve_flag ? stv_q : stv_q + 1'b1;
    else
      stv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stv_q  <= '0;
      gnt_q  <= '0;
      link_q <= 1'b0;
    end else begin
      stv_q  <= stv_d;
      gnt_q  <= gnt_d;
      link_q <= (src != SRC_NONE);
    end
  end

  assign gnt        = gnt_q;
  assign link_valid = link_q;

endmodule

// File: rtl/lnk_arb_chk.sv
module lnk_arb_chk #(
  parameter int NUM_FLOWS = 4,
  parameter int SLOTS     = 8,
  parameter logic [NUM_FLOWS-1:0] HI_MASK = 4'b0011,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_FLOWS-1:0] req,
  input logic [NUM_FLOWS-1:0] gnt,
  input logic                 link_valid,
  input logic [SLOT_W-1:0]    ptr,
  input logic [NUM_FLOWS-1:0] tok_nz,
  input logic                 starve,
  input logic [NUM_FLOWS-1:0] hi_elig,
  input logic [NUM_FLOWS-1:0] lo_elig,
  input logic                 tdm_hit
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R2

  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((gnt & $past(req)) != '0)); // R2

  AST_LINK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid == (gnt != '0)); // R10

  AST_TOKEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((gnt & ~$past(tok_nz)) == '0)); // R8

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(ptr) == (int'($past(ptr)) + 1) % SLOTS)); // R3

  AST_STARVE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (starve && (lo_elig != '0) && !tdm_hit) |=> ((gnt & ~HI_MASK) != '0)); // R7

  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!starve && (hi_elig != '0) && !tdm_hit) |=> ((gnt & HI_MASK) != '0)); // R5

endmodule

bind lnk_arb lnk_arb_chk #(
  .NUM_FLOWS(NUM_FLOWS), .SLOTS(SLOTS), .HI_MASK(HI_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .link_valid(link_valid),
  .ptr(slot_ptr), .tok_nz(tok_nz), .starve(starve_flag),
  .hi_elig(hi_elig), .lo_elig(lo_elig), .tdm_hit(tdm_hit)
);

// File: tb/lnk_arb_test.sv
module lnk_arb_test;

  localparam int NF = 4;
  localparam int NS = 8;
  localparam int TMAX = 4;
  localparam int PER = 2;
  localparam int SLIM = 15;
  localparam logic [NF-1:0] HI = 4'b0011;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] req;
  logic          tbl_we;
  logic [2:0]    tbl_addr;
  logic          tbl_valid;
  logic [1:0]    tbl_flow;
  logic [NF-1:0] gnt;
  logic          link_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #5 clk = ~clk;

  lnk_arb #(.NUM_FLOWS(NF), .SLOTS(NS), .TOK_W(4), .TOK_MAX(TMAX),
            .REFILL_PERIOD(PER), .STARVE_LIMIT(SLIM), .HI_MASK(HI)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_valid(tbl_valid), .tbl_flow(tbl_flow), .gnt(gnt), .link_valid(link_valid)
  );

  // behavioural reference
  int m_ptr, m_div, m_stv;
  int m_tok [NF];
  int m_last [2];
  bit m_tv [NS];
  int m_tf [NS];
  logic [NF-1:0] exp_gnt;
  bit exp_link;
  int low_grants;

  function automatic int cls_of(int f);
    return HI[f] ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_div = 0; m_stv = 0;
      for (int i = 0; i < NF; i++) m_tok[i] = TMAX;
      m_last[0] = NF - 1; m_last[1] = NF - 1;
      for (int s = 0; s < NS; s++) begin m_tv[s] = 0; m_tf[s] = 0; end
      exp_gnt = '0; exp_link = 0;
    end else begin
      bit el [NF];
      bit lo_any, hi_any;
      int g, cls;
      g = -1; cls = -1; lo_any = 0; hi_any = 0;
      for (int i = 0; i < NF; i++) begin
        el[i] = req[i] && (m_tok[i] > 0);
        if (el[i] && cls_of(i) == 1) hi_any = 1;
        if (el[i] && cls_of(i) == 0) lo_any = 1;
      end
      if (m_tv[m_ptr] && el[m_tf[m_ptr]]) g = m_tf[m_ptr];
      else begin
        if (m_stv == SLIM && lo_any) cls = 0;
        else if (hi_any) cls = 1;
        else if (lo_any) cls = 0;
        if (cls >= 0) begin
          for (int off = 1; off <= NF; off++) begin
            int idx;
            idx = (m_last[cls] + off) % NF;
            if (g < 0 && el[idx] && cls_of(idx) == cls) g = idx;
          end
          m_last[cls] = g;
        end
      end
      if (lo_any && !(g >= 0 && cls_of(g) == 0)) m_stv = (m_stv < SLIM) ? m_stv + 1 : SLIM;
      else m_stv = 0;
      for (int i = 0; i < NF; i++) begin
        int t;
        t = m_tok[i] - ((g == i) ? 1 : 0);
        if (m_div == PER - 1) t = (t + 1 > TMAX) ? TMAX : t + 1;
        m_tok[i] = t;
      end
      m_div = (m_div + 1) % PER;
      m_ptr = (m_ptr + 1) % NS;
      if (tbl_we) begin m_tv[tbl_addr] = tbl_valid; m_tf[tbl_addr] = int'(tbl_flow); end
      exp_gnt = (g >= 0) ? NF'(1 << g) : '0;
      exp_link = (g >= 0);
      if (g >= 0 && cls_of(g) == 0) low_grants++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      compared++;
      if (gnt !== exp_gnt) begin
        mismatched++;
        $display("FAIL %s: gnt actual %b expected %b", phase, gnt, exp_gnt);
      end
      compared++;
      if (link_valid !== exp_link) begin
        mismatched++;
        $display("FAIL R10: link_valid actual %b expected %b", link_valid, exp_link);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_slot(input int a, input bit v, input int f);
    tbl_we = 1; tbl_addr = 3'(a); tbl_valid = v; tbl_flow = 2'(f);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic check_bit(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  initial begin
    rst_n = 0; req = '0; tbl_we = 0; tbl_addr = '0; tbl_valid = 0; tbl_flow = '0;
    req = 4'b1111;
    run(3);
    check_bit(gnt == '0, "R1 gnt in reset", int'(gnt), 0);
    check_bit(link_valid == 1'b0, "R1 link_valid in reset", int'(link_valid), 0);
    req = '0;
    rst_n = 1;
    run(2);

    phase = "R2 R6 R8 R9 high pair round robin with buckets";
    req = 4'b0011; run(30);

    phase = "R5 R7 high pair over low flow with starvation bound";
    low_grants = 0;
    req = 4'b0111; run(40);
    check_bit(low_grants >= 2, "R7 low class served within bound", low_grants, 2);

    phase = "R6 R8 low pair round robin";
    req = 4'b1100; run(20);

    phase = "R9 drain and refill single flow";
    req = 4'b0000; run(10);
    req = 4'b1000; run(20);

    phase = "R11 slot programming";
    req = 4'b0000;
    wr_slot(1, 1, 3);
    wr_slot(5, 1, 2);
    wr_slot(6, 1, 0);
    run(6);

    phase = "R3 reserved slots with all flows requesting";
    req = 4'b1111; run(40);

    phase = "R4 reserved owners idle fall through to best effort";
    req = 4'b0010; run(24);

    phase = "R11 slot cleared then all requesting";
    req = 4'b1111;
    wr_slot(1, 0, 3);
    run(24);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule